// File: doc/BRIEF.md
# Hardware Ticket Lock

A shared lock engine for a fixed set of requesters that hands out ownership strictly in the order requests were accepted. Two wrapping counters do the work. One issues tickets. The other names the ticket currently allowed to hold the lock. An acquire takes the issuing counter's value as the requester's ticket and advances it. This fetch-and-increment happens inside the unit, so requests that arrive together never collide. A requester owns the lock while its ticket equals the serving counter. A release advances the serving counter to pass ownership to the next ticket.

Each requester drives an acquire level and a release pulse. It sees its ticket and a grant bit. Requests that land in the same cycle are numbered in ascending requester index. Since ownership is decided by ticket comparison rather than by a priority arbiter, service is first-come first-served and nobody starves.

Top module: `ticket_lock_unit`

## Requirements
- R1: After rst_ni is released, both counters are zero, every ticket_o field is zero, grant_o is all zero and err_o is low.
- R2: An acquire_i bit seen at a rising edge from a requester with no outstanding ticket gives it the issuing counter's value as its ticket in ticket_o (field i at bits i*TKT_W +: TKT_W), visible after that edge, and advances the issuing counter.
- R3: Acquires from several idle requesters at the same edge receive consecutive tickets, the lowest requester index taking the lowest value.
- R4: grant_o[i] is high exactly while requester i holds an outstanding ticket equal to the serving counter; at most one grant bit is high.
- R5: A release_i pulse from the granted requester advances the serving counter by one and retires its ticket; the next ticket's owner sees grant_o from the following cycle.
- R6: A release_i bit from a requester not granted at that edge changes no state, and err_o is high for exactly the next cycle.
- R7: An acquire from a requester that already holds an outstanding ticket is ignored: its ticket and the issuing counter stay unchanged.
- R8: Both counters are TKT_W bits wide, with TKT_W of at least clog2(N_REQ)+1, and wrap modulo 2^TKT_W without disturbing grant order.
- R9: Grants occur in the order tickets were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acquire_i | input | N_REQ | Per-requester acquire request |
| release_i | input | N_REQ | Per-requester release pulse |
| ticket_o | output | N_REQ*TKT_W | Per-requester ticket, field i at bits i*TKT_W +: TKT_W |
| grant_o | output | N_REQ | Per-requester lock held |
| err_o | output | 1 | Release from a non-holder seen in the previous cycle |

## Verification
The bench targets same-cycle acquires in every combination of requesters. A design with a wrong prefix count would hand out duplicate tickets, or number the requesters out of index order. The bench keeps enough traffic going that both counters wrap many times, which exposes ordering tied to counter magnitude instead of equality. It also mixes stray releases from waiting or idle requesters with legal ones. A design that did not filter them would skip a ticket or grant two owners, and one that did not flag them would leave err_o low. Repeat acquires from ticket holders are checked too, because an engine that re-ticketed them would burn issue slots.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  function automatic int min_tkt_w(input int n);
    return $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/tlu_ticket_alloc.sv
module tlu_ticket_alloc #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_REQ-1:0]            take_i,
  output logic [N_REQ-1:0][TKT_W-1:0] new_tkt_o
);
  logic [TKT_W-1:0] next_q;
  logic [N_REQ:0][TKT_W-1:0] pre;

  assign pre[0] = '0;
  for (genvar i = 0; i < N_REQ; i++) begin : g_pre
    assign pre[i+1]      = pre[i] + TKT_W'(take_i[i]);
    assign new_tkt_o[i]  = next_q + pre[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) next_q <= '0;
    else         next_q <= next_q + pre[N_REQ];
  end

  a_r7_next_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i == '0) |=> $stable(next_q));
  a_r2_next_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(take_i) |=> (next_q == TKT_W'($past(next_q) + 1'b1)));
endmodule

// File: rtl/tlu_slot.sv
module tlu_slot #(
  parameter int TKT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [TKT_W-1:0] new_tkt_i,
  input  logic             retire_i,
  output logic             valid_o,
  output logic [TKT_W-1:0] ticket_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      ticket_o <= '0;
    end else if (retire_i) begin
      valid_o  <= 1'b0;
    end else if (take_i) begin
      valid_o  <= 1'b1;
      ticket_o <= new_tkt_i;
    end
  end

  a_r7_ticket_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !retire_i) |=> (valid_o && $stable(ticket_o)));
endmodule

// File: rtl/tlu_serve_ctr.sv
module tlu_serve_ctr #(
  parameter int TKT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             stray_i,
  output logic [TKT_W-1:0] serving_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serving_o <= '0;
      err_o     <= 1'b0;
    end else begin
      if (advance_i) serving_o <= serving_o + 1'b1;
      err_o <= stray_i;
    end
  end

  a_r5_serve_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |=> (serving_o == TKT_W'($past(serving_o) + 1'b1)));
  a_r6_serve_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> $stable(serving_o));
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter int N_REQ = 4,
  parameter int TKT_W = tlu_pkg::min_tkt_w(N_REQ)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_REQ-1:0]       acquire_i,
  input  logic [N_REQ-1:0]       release_i,
  output logic [N_REQ*TKT_W-1:0] ticket_o,
  output logic [N_REQ-1:0]       grant_o,
  output logic                   err_o
);
  logic [N_REQ-1:0]            valid;
  logic [N_REQ-1:0]            take;
  logic [N_REQ-1:0]            retire;
  logic [N_REQ-1:0][TKT_W-1:0] new_tkt;
  logic [N_REQ-1:0][TKT_W-1:0] tkt;
  logic [TKT_W-1:0]            serving;

  assign take   = acquire_i & ~valid;
  assign retire = release_i & grant_o;

  tlu_ticket_alloc #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_alloc (
    .clk_i, .rst_ni, .take_i(take), .new_tkt_o(new_tkt)
  );

  for (genvar i = 0; i < N_REQ; i++) begin : g_slot
    tlu_slot #(.TKT_W(TKT_W)) u_slot (
      .clk_i, .rst_ni,
      .take_i(take[i]), .new_tkt_i(new_tkt[i]), .retire_i(retire[i]),
      .valid_o(valid[i]), .ticket_o(tkt[i])
    );
    assign grant_o[i] = valid[i] && (tkt[i] == serving);
    assign ticket_o[i*TKT_W +: TKT_W] = tkt[i];
  end

  tlu_serve_ctr #(.TKT_W(TKT_W)) u_serve (
    .clk_i, .rst_ni,
    .advance_i(|retire), .stray_i(|(release_i & ~grant_o)),
    .serving_o(serving), .err_o
  );

  initial begin
    a_r8_width: assert (TKT_W >= tlu_pkg::min_tkt_w(N_REQ));
  end

  a_r4_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  a_r6_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(release_i & ~grant_o)) |=> err_o);
  a_r6_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i & ~grant_o) == '0 |=> !err_o);
  a_r5_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|retire) |=> ((grant_o & $past(grant_o)) == '0));
endmodule

// File: tb/sim_ticket_lock_unit.sv
module sim_ticket_lock_unit;
  localparam int N = 4;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] acq = '0, rel = '0;
  logic [N*W-1:0] tkt_o;
  logic [N-1:0] gnt_o;
  logic err;

  always #5 clk = ~clk;

  ticket_lock_unit #(.N_REQ(N), .TKT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .acquire_i(acq), .release_i(rel),
    .ticket_o(tkt_o), .grant_o(gnt_o), .err_o(err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] m_next = '0, m_serv = '0;
  logic [W-1:0] m_tkt [N];
  logic [N-1:0] m_val = '0;
  logic m_err = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_gnt();
    logic [N-1:0] g;
    for (int i = 0; i < N; i++) g[i] = m_val[i] && (m_tkt[i] == m_serv);
    return g;
  endfunction

  task automatic check_all(input string req);
    logic [N-1:0] g;
    g = m_gnt();
    chk(gnt_o == g, {req, "/R4 grant"}, gnt_o, g);
    chk(err == m_err, {req, "/R6 err"}, err, m_err);
    for (int i = 0; i < N; i++)
      if (m_val[i])
        chk(tkt_o[i*W +: W] == m_tkt[i], {req, "/R2 ticket"}, tkt_o[i*W +: W], m_tkt[i]);
  endtask

  // drive at negedge, update model from pre-edge state, sample after posedge
  task automatic step(input logic [N-1:0] a, input logic [N-1:0] r, input string req);
    logic [N-1:0] g;
    logic [N-1:0] nv;
    @(negedge clk);
    acq = a;
    rel = r;
    g = m_gnt();
    nv = m_val;
    m_err = |(r & ~g);
    for (int i = 0; i < N; i++) begin
      if (r[i] && g[i]) begin
        nv[i] = 1'b0;
        m_serv = m_serv + 1'b1;
      end else if (a[i] && !m_val[i]) begin
        nv[i] = 1'b1;
        m_tkt[i] = m_next;
        m_next = m_next + 1'b1;
      end
    end
    m_val = nv;
    @(posedge clk);
    #2;
    check_all(req);
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [N-1:0] a, r, g;
    for (int i = 0; i < N; i++) m_tkt[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(tkt_o == '0, "R1 tickets", tkt_o, 0);
    chk(gnt_o == '0, "R1 grant", gnt_o, 0);
    chk(err == 1'b0, "R1 err", err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step('0, '0, "R1 idle");
    step(4'b0001, '0, "R2 first acquire");
    chk(gnt_o == 4'b0001, "R1 first granted", gnt_o, 1);
    step(4'b1110, '0, "R3 simultaneous");
    chk(tkt_o == {3'd3, 3'd2, 3'd1, 3'd0}, "R3 order", tkt_o, {3'd3, 3'd2, 3'd1, 3'd0});
    step(4'b0101, '0, "R7 repeat acquire");
    chk(tkt_o[0 +: W] == 3'd0, "R7 ticket kept", tkt_o[0 +: W], 0);
    step(4'b0010, 4'b0010, "R6 stray release");
    chk(gnt_o == 4'b0001, "R6 grant unchanged", gnt_o, 1);
    step('0, '0, "R6 err one cycle");
    step('0, 4'b0001, "R5 release holder");
    chk(gnt_o == 4'b0010, "R5 next granted", gnt_o, 2);
    step(4'b0001, 4'b0010, "R9 release and requeue");
    chk(gnt_o == 4'b0100, "R9 fifo", gnt_o, 4);
    // sweep: all acquire masks, mixed legal and stray releases, many wraps (R8)
    lf = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = (c < 256) ? 4'(c) : lf[3:0];
      g = m_gnt();
      if (lf[7:5] != 3'b000) r = g;
      else r = lf[11:8];
      step(a, r, (m_next < m_serv) ? "R8 wrap sweep" : "R9 sweep");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule